// File: doc/BRIEF.md
# Variable-Size Circulant Rotator

This block applies one quasi-cyclic permutation submatrix to a data subblock. A subblock of `z` bits sits in the low end of a fixed-width datapath (96 bits by default). The block rotates it circularly modulo `z`, not modulo the physical width. The expansion factor `z` is chosen per word at run time from the sizes 24, 28, ... 96. A signed shift entry selects the rotation. An entry of -1 stands for an all-zero submatrix. A direction select adds a second rotation sense, which forms a subblock rotated the other way by a count.

Bits at and above `z` never reach the output. A shift entry that does not fit the active size, or an unsupported size, raises an error flag and zeroes the word. The result leaves through an optional output register, and the valid flag is delayed to match.

Top module: `qc_rotator`

## Requirements
- R1: With `in_left`=0 and shift `s` in 0..z-1, output bit `i` (i<z) equals input bit `(i+s) mod z`.
- R2: Output bits `z` through W-1 are always zero.
- R3: With `in_left`=1 and shift `s` in 0..z-1, output bit `i` (i<z) equals input bit `(i-s) mod z`, taken nonnegative.
- R4: A shift of -1 (all ones in the 8-bit two's complement `in_shift`) gives an all-zero word with `out_err`=0, in either direction.
- R5: A shift of `z` or more, or below -1, gives `out_err`=1 and an all-zero word.
- R6: An `in_z` that is not a multiple of 4, or lies outside 24..96, gives `out_err`=1 and an all-zero word.
- R7: Input bits at positions `z` and above have no effect on the result.
- R8: With the output register on (default), a word presented while `in_valid`=1 appears one clock later with `out_valid`=1. After reset `out_valid`, `out_err` and `out_data` are zero.
- R9: When `out_valid` is 0, `out_data` is all zero and `out_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is present |
| in_data | input | 96 | Subblock in bits z-1..0 |
| in_z | input | 7 | Active expansion factor |
| in_shift | input | 8 | Signed shift entry, -1 means zero submatrix |
| in_left | input | 1 | 0: permutation sense, 1: opposite rotation |
| out_valid | output | 1 | Result is present |
| out_data | output | 96 | Rotated subblock, upper bits zero |
| out_err | output | 1 | Shift or size was out of range |

## Verification
The assertions take for granted that `in_valid`, `in_z`, `in_shift` and `in_left` are known, driven values on every clock edge after reset. They also assume that `in_valid` is held low throughout reset. Their checks of bit count and error behaviour hold for any data pattern. The stimulus changes inputs only on the falling edge and drives `in_valid` low during reset. It sweeps every legal `z` with shifts 0, 1, z-1 and a mid value in both directions, and fills the bits above `z` with random data. Separate words cover illegal sizes and out-of-range shifts.

// File: rtl/qcr_pkg.sv
package qcr_pkg;
   localparam int unsigned DEF_WIDTH = 96;
   localparam int unsigned DEF_ZMIN  = 24;
   localparam int unsigned DEF_ZSTEP = 4;

   function automatic int unsigned sel_width(input int unsigned w);
      return $clog2(w + 1);
   endfunction
endpackage

// File: rtl/qcr_decode.sv
module qcr_decode #(
   parameter int unsigned W     = 96,
   parameter int unsigned ZMIN  = 24,
   parameter int unsigned ZSTEP = 4,
   parameter int unsigned ZW    = 7,
   parameter int unsigned SHW   = ZW + 1
) (
   input  logic [ZW-1:0]  z,
   input  logic [SHW-1:0] shift,
   input  logic           left,
   output logic [W-1:0]   mask,
   output logic [ZW-1:0]  amt_r,
   output logic [ZW-1:0]  amt_l,
   output logic           kill,
   output logic           err
);
   localparam logic [ZW-1:0] ZLO = ZW'(ZMIN);
   localparam logic [ZW-1:0] ZHI = ZW'(W);
   localparam logic [ZW-1:0] ZST = ZW'(ZSTEP);

   logic          z_ok, is_nil, is_neg, too_big;
   logic [ZW-1:0] s;

   // lane enable: one bit per physical position below the active size
   for (genvar i = 0; i < W; i++) begin : g_mask
      assign mask[i] = (ZW'(i) < z);
   end

   always_comb begin
      z_ok    = (z >= ZLO) && (z <= ZHI) && ((z % ZST) == '0);
      is_nil  = (shift == {SHW{1'b1}});
      is_neg  = shift[SHW-1] && !is_nil;
      too_big = !shift[SHW-1] && (shift[SHW-2:0] >= z);
      err     = !z_ok || is_neg || too_big;
      kill    = err || is_nil;
      s       = shift[ZW-1:0];
      // opposite sense equals permutation sense by z-s; s=0 gives z, which
      // the split shift handles as identity
      amt_r   = left ? (z - s) : s;
      amt_l   = z - amt_r;
   end
endmodule

// File: rtl/qcr_shift.sv
module qcr_shift #(
   parameter int unsigned W    = 96,
   parameter int unsigned AW   = 7,
   parameter bit          LEFT = 1'b0
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);
   logic [W-1:0] stg [AW+1];

   assign stg[0] = din;

   for (genvar k = 0; k < AW; k++) begin : g_stage
      if (LEFT) begin : g_l
         assign stg[k+1] = amt[k] ? (stg[k] << (2 ** k)) : stg[k];
      end else begin : g_r
         assign stg[k+1] = amt[k] ? (stg[k] >> (2 ** k)) : stg[k];
      end
   end

   assign dout = stg[AW];
endmodule

// File: rtl/qcr_stage.sv
module qcr_stage #(
   parameter int unsigned W   = 96,
   parameter bit          REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         v_i,
   input  logic [W-1:0] d_i,
   input  logic         e_i,
   output logic         v_o,
   output logic [W-1:0] d_o,
   output logic         e_o
);
   if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_o <= 1'b0;
            d_o <= '0;
            e_o <= 1'b0;
         end else begin
            v_o <= v_i;
            d_o <= d_i;
            e_o <= e_i;
         end
      end
   end else begin : g_comb
      assign v_o = v_i;
      assign d_o = d_i;
      assign e_o = e_i;
   end
endmodule

// File: rtl/qc_rotator.sv
module qc_rotator #(
   parameter int unsigned W       = qcr_pkg::DEF_WIDTH,
   parameter int unsigned ZMIN    = qcr_pkg::DEF_ZMIN,
   parameter int unsigned ZSTEP   = qcr_pkg::DEF_ZSTEP,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned ZW     = qcr_pkg::sel_width(W),
   localparam int unsigned SHW    = ZW + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [W-1:0]   in_data,
   input  logic [ZW-1:0]  in_z,
   input  logic [SHW-1:0] in_shift,
   input  logic           in_left,
   output logic           out_valid,
   output logic [W-1:0]   out_data,
   output logic           out_err
);
   if (ZMIN == 0 || ZMIN > W) begin : g_bad_zmin
      $error("ZMIN must lie in 1..W");
   end
   if (ZSTEP == 0 || (W % ZSTEP) != 0) begin : g_bad_step
      $error("W must be a multiple of ZSTEP");
   end

   logic [W-1:0]  mask, din_m, part_r, part_l, rot_m, res_d;
   logic [ZW-1:0] amt_r, amt_l;
   logic          kill, dec_err, res_e;

   qcr_decode #(.W(W), .ZMIN(ZMIN), .ZSTEP(ZSTEP), .ZW(ZW), .SHW(SHW)) u_dec (
      .z(in_z), .shift(in_shift), .left(in_left),
      .mask(mask), .amt_r(amt_r), .amt_l(amt_l), .kill(kill), .err(dec_err)
   );

   assign din_m = in_data & mask;

   qcr_shift #(.W(W), .AW(ZW), .LEFT(1'b0)) u_sr (
      .din(din_m), .amt(amt_r), .dout(part_r)
   );
   qcr_shift #(.W(W), .AW(ZW), .LEFT(1'b1)) u_sl (
      .din(din_m), .amt(amt_l), .dout(part_l)
   );

   assign rot_m = (part_r | part_l) & mask;
   assign res_d = (in_valid && !kill) ? rot_m : '0;
   assign res_e = in_valid && dec_err;

   qcr_stage #(.W(W), .REG(REG_OUT)) u_out (
      .clk(clk), .rst_n(rst_n),
      .v_i(in_valid), .d_i(res_d), .e_i(res_e),
      .v_o(out_valid), .d_o(out_data), .e_o(out_err)
   );

   // rotation is a permutation: the count of ones in the live lanes is kept
   p_ones_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !kill) |-> ($countones(rot_m) == $countones(din_m)));

   p_nil_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_shift == {SHW{1'b1}}) |-> !dec_err);

   p_big_shift_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_shift[SHW-1] && in_shift[SHW-2:0] >= in_z) |-> dec_err);

   p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_data == '0));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_data == '0 && !out_err));

   if (REG_OUT) begin : g_lat_chk
      p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(in_valid));
   end
endmodule

// File: tb/tb_qc_rotator.sv
module tb_qc_rotator;
   localparam int W   = 96;
   localparam int ZW  = 7;
   localparam int SHW = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [W-1:0]   in_data = '0;
   logic [ZW-1:0]  in_z = 7'd24;
   logic [SHW-1:0] in_shift = '0;
   logic           in_left = 1'b0;
   logic           out_valid;
   logic [W-1:0]   out_data;
   logic           out_err;

   typedef struct {
      logic [W-1:0] data;
      logic         err;
      string        tag;
   } exp_t;

   exp_t exq[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   run_done = 1'b0;
   bit   mon_on   = 1'b0;

   always #4 clk = ~clk;

   qc_rotator dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_z(in_z), .in_shift(in_shift), .in_left(in_left),
      .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
   );

   function automatic exp_t model(input logic [W-1:0] d, input int z,
                                  input int s, input bit left, input string tag);
      exp_t e;
      e.data = '0;
      e.err  = 1'b0;
      e.tag  = tag;
      if (z < 24 || z > 96 || (z % 4) != 0 || s < -1 || s >= z) begin
         e.err = 1'b1;
      end else if (s >= 0) begin
         for (int i = 0; i < z; i++) begin
            int src;
            src = left ? ((i - s + z) % z) : ((i + s) % z);
            e.data[i] = d[src];
         end
      end
      return e;
   endfunction

   function automatic logic [W-1:0] rnd96();
      return {$urandom(), $urandom(), $urandom()};
   endfunction

   task automatic drive(input logic [W-1:0] d, input int z, input int s,
                        input bit left, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      in_z     = ZW'(z);
      in_shift = SHW'(s);
      in_left  = left;
      exq.push_back(model(d, z, s, left, tag));
   endtask

   task automatic idle(input logic [W-1:0] d);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = d;
   endtask

   // monitor: outputs registered at posedge, read just after the falling edge
   always @(negedge clk) begin
      #1;
      if (mon_on) begin
         if (out_valid) begin
            if (exq.size() == 0) begin
               n_checks++;
               n_errors++;
               $display("FAIL R8: out_valid=1 actual, no word expected");
            end else begin
               exp_t e;
               e = exq.pop_front();
               n_checks++;
               if (out_data !== e.data || out_err !== e.err) begin
                  n_errors++;
                  $display("FAIL %s: actual data=%h err=%b expected data=%h err=%b",
                           e.tag, out_data, out_err, e.data, e.err);
               end
            end
         end else begin
            n_checks++;
            if (out_data !== '0 || out_err !== 1'b0) begin
               n_errors++;
               $display("FAIL R9: actual data=%h err=%b expected data=0 err=0",
                        out_data, out_err);
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!run_done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      n_checks++;
      if (out_valid !== 1'b0 || out_err !== 1'b0 || out_data !== '0) begin
         n_errors++;
         $display("FAIL R8: reset actual v=%b e=%b d=%h expected 0 0 0",
                  out_valid, out_err, out_data);
      end
      @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R1 R3 R2 R7: every legal size, corner and mid shifts, garbage above z
      for (int z = 24; z <= 96; z += 4) begin
         for (int dir = 0; dir < 2; dir++) begin
            drive(rnd96(), z, 0,     dir[0], dir ? "R3 s=0" : "R1 s=0");
            drive(rnd96(), z, 1,     dir[0], dir ? "R3 s=1" : "R1 s=1");
            drive(rnd96(), z, z - 1, dir[0], dir ? "R3 s=z-1" : "R1 s=z-1");
            drive(rnd96(), z, z / 3, dir[0], "R2/R7 mid shift");
         end
      end
      // single-bit walk, one bit moves to a known lane
      drive(96'h1, 24, 5, 1'b0, "R1 single bit");
      drive(96'h1, 24, 5, 1'b1, "R3 single bit");
      drive({W{1'b1}}, 40, 7, 1'b0, "R7 ones above z");
      // zero submatrix
      drive(rnd96(), 48, -1, 1'b0, "R4 nil perm");
      drive(rnd96(), 96, -1, 1'b1, "R4 nil left");
      // bad shifts
      drive(rnd96(), 24, 24,  1'b0, "R5 s=z");
      drive(rnd96(), 60, 100, 1'b1, "R5 s>z");
      drive(rnd96(), 60, -2,  1'b0, "R5 s=-2");
      drive(rnd96(), 96, -128, 1'b0, "R5 s=-128");
      // bad sizes
      drive(rnd96(), 25, 0, 1'b0, "R6 z=25");
      drive(rnd96(), 20, 3, 1'b0, "R6 z=20");
      drive(rnd96(), 100, 3, 1'b0, "R6 z=100");
      drive(rnd96(), 0, 0, 1'b1, "R6 z=0");
      // idle cycles with live data on the pins
      idle(rnd96());
      idle(rnd96());
      drive(rnd96(), 72, 13, 1'b1, "R8 after gap");
      idle('0);
      repeat (3) @(negedge clk);
      #2;
      n_checks++;
      if (exq.size() != 0) begin
         n_errors++;
         $display("FAIL R8: actual %0d words outstanding expected 0", exq.size());
      end
      run_done = 1'b1;
      finish_run();
   end
endmodule